// File: doc/BRIEF.md
# Regulator Setpoint Soft-Start Sequencer

This block is the digital side of a voltage regulator's output setpoint control. Three settings sit behind a small register write port: an 8-bit setpoint code, a 2-bit range selector and a 2-bit soft-start time selector. During reset, a 2-bit strap class picks the default setpoint code. The analog loop reads the present target voltage from `target_uv`, in integer microvolts.

When enable rises, the block takes a snapshot of the setpoint, range and soft-start time. It then ramps the target from zero to the snapshot voltage. Writes that arrive during that ramp update the registers but not the ramp in progress. When the ramp ends, `ss_done` rises. From then on the target follows the live registers at a fixed rate, and `busy` is high while the target and the setpoint differ. Dropping enable clears the target and the done flag at once and discards the snapshot.

Top module: `ss_setpoint_seq`

## Requirements
- R1: Sampled during reset, the strap class sets the setpoint code: 00 (short to ground) gives 0x46, 01 (short to supply) gives 0x5F, 10 (resistor to ground) gives 0x5A, 11 (resistor to supply) gives 0x78. Reset also sets the range code to 10 and the time code to 00. After reset `target_uv` is 0 and `ss_done` and `busy` are low.
- R2: The setpoint voltage in µV is 400000 + code×1250×2^range for range codes 00, 01 and 10, and 800000 + code×10000 for range code 11.
- R3: A write with `wr_en` high uses `wr_addr` to pick the register: 0 writes the code from `wr_data[7:0]`, 1 writes the range from `wr_data[1:0]`, 2 writes the time code from `wr_data[1:0]`, and 3 has no effect.
- R4: The first clock edge with `en` high takes the snapshot and leaves the target at 0. Each later edge adds step = (snapshot_uv >> (8+time code)) + 1, and the last step clamps to the snapshot. `ss_done` rises on the edge where the target reaches the snapshot.
- R5: Writes made during soft start do not change the ramp. It ends at the voltage captured when soft start began.
- R6: Once `ss_done` is high, the target moves toward the live setpoint voltage by TRACK_STEP_UV (default 1250 µV) per clock and clamps when it arrives. `busy` is high exactly while the target differs from the live setpoint.
- R7: One edge after `en` is sampled low, `target_uv` is 0 and `ss_done` and `busy` are low.
- R8: Values written while `en` is low, the time code included, apply to the next soft start.
- R9: During soft start the target never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one ramp tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Regulator enable |
| strap_class | input | 2 | Decoded strap class, sampled during reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| target_uv | output | UV_W (22) | Present target voltage in µV |
| ss_done | output | 1 | Soft start complete |
| busy | output | 1 | Tracking ramp in progress after soft start |

## Verification
The hardest case to reach is a setpoint write that lands in the middle of a soft-start ramp. The bench has to show that the ramp still ends exactly at the old snapshot and only then slews to the new value. To get there, it enables the block and waits a few cycles. It then writes a new code while the ramp is still climbing. A behavioural model runs in step with the design and follows every cycle of the deferred ramp and the tracking slew that comes after it. A large range switch after completion also drives a long downward tracking run.

// File: rtl/ss_pkg.sv
package ss_pkg;
    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_SOFT  = 2'd1,
        PH_TRACK = 2'd2
    } phase_e;

    localparam int unsigned CODE_W = 8;
    localparam int unsigned SEL_W  = 2;

    function automatic logic [CODE_W-1:0] strap_default(input logic [SEL_W-1:0] cls);
        case (cls)
            2'b00:   strap_default = 8'h46;
            2'b01:   strap_default = 8'h5F;
            2'b10:   strap_default = 8'h5A;
            default: strap_default = 8'h78;
        endcase
    endfunction
endpackage

// File: rtl/ss_cfg_regs.sv
module ss_cfg_regs
    import ss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  strap_class,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] code_o,
    output logic [SEL_W-1:0]  range_o,
    output logic [SEL_W-1:0]  sstime_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [SEL_W-1:0]  rng;
        logic [SEL_W-1:0]  sst;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.code = strap_default(strap_class);
            cfg_d.rng  = 2'b10;
            cfg_d.sst  = 2'b00;
        end else if (wr_en) begin
            case (wr_addr)
                2'd0:    cfg_d.code = wr_data;
                2'd1:    cfg_d.rng  = wr_data[SEL_W-1:0];
                2'd2:    cfg_d.sst  = wr_data[SEL_W-1:0];
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign code_o   = cfg_q.code;
    assign range_o  = cfg_q.rng;
    assign sstime_o = cfg_q.sst;
endmodule

// File: rtl/ss_uv_map.sv
module ss_uv_map
    import ss_pkg::*;
#(
    parameter int unsigned UV_W     = 22,
    parameter int unsigned LSB_UV   = 1250,
    parameter int unsigned BASE_LO  = 400000,
    parameter int unsigned BASE_HI  = 800000
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [SEL_W-1:0]  range_i,
    output logic [UV_W-1:0]   uv_o
);
    localparam logic [UV_W-1:0] LSB_V = UV_W'(LSB_UV);
    localparam logic [UV_W-1:0] LO_V  = UV_W'(BASE_LO);
    localparam logic [UV_W-1:0] HI_V  = UV_W'(BASE_HI);

    logic [UV_W-1:0] prod;
    logic [UV_W-1:0] scaled;

    always_comb begin
        prod   = UV_W'(code_i) * LSB_V;
        scaled = prod << range_i;
        uv_o   = ((range_i == 2'b11) ? HI_V : LO_V) + scaled;
    end
endmodule

// File: rtl/ss_ramp_core.sv
module ss_ramp_core
    import ss_pkg::*;
#(
    parameter int unsigned UV_W          = 22,
    parameter int unsigned TRACK_STEP_UV = 1250,
    parameter int unsigned MIN_SHIFT     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [UV_W-1:0]  goal_uv,
    input  logic [SEL_W-1:0] sstime,
    output logic [UV_W-1:0]  target_uv,
    output logic             ss_done,
    output logic             busy
);
    localparam logic [UV_W-1:0] TSTEP = UV_W'(TRACK_STEP_UV);
    localparam logic [3:0]      SHB   = 4'(MIN_SHIFT);

    typedef struct packed {
        phase_e          phase;
        logic [UV_W-1:0] target;
        logic [UV_W-1:0] snap;
        logic [UV_W-1:0] step;
    } ramp_t;

    ramp_t st_d, st_q;
    logic [UV_W:0]   sum;
    logic [UV_W:0]   up;
    logic [UV_W-1:0] gap;
    logic [3:0]      sh;

    always_comb begin
        st_d = st_q;
        sh   = SHB + {2'b00, sstime};
        sum  = {1'b0, st_q.target} + {1'b0, st_q.step};
        up   = {1'b0, st_q.target} + {1'b0, TSTEP};
        gap  = st_q.target - goal_uv;
        if (!rst_n || !en) begin
            st_d.phase  = PH_OFF;
            st_d.target = '0;
            st_d.snap   = '0;
            st_d.step   = '0;
        end else begin
            case (st_q.phase)
                PH_OFF: begin
                    st_d.phase  = PH_SOFT;
                    st_d.snap   = goal_uv;
                    st_d.step   = (goal_uv >> sh) + UV_W'(1);
                    st_d.target = '0;
                end
                PH_SOFT: begin
                    if (sum >= {1'b0, st_q.snap}) begin
                        st_d.target = st_q.snap;
                        st_d.phase  = PH_TRACK;
                    end else begin
                        st_d.target = sum[UV_W-1:0];
                    end
                end
                PH_TRACK: begin
                    if (st_q.target < goal_uv) begin
                        st_d.target = (up >= {1'b0, goal_uv}) ? goal_uv : up[UV_W-1:0];
                    end else if (st_q.target > goal_uv) begin
                        st_d.target = (gap <= TSTEP) ? goal_uv : (st_q.target - TSTEP);
                    end
                end
                default: st_d.phase = PH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign target_uv = st_q.target;
    assign ss_done   = (st_q.phase == PH_TRACK);
    assign busy      = (st_q.phase == PH_TRACK) && (st_q.target != goal_uv);
endmodule

// File: rtl/ss_setpoint_seq.sv
module ss_setpoint_seq
    import ss_pkg::*;
#(
    parameter int unsigned UV_W          = 22,
    parameter int unsigned TRACK_STEP_UV = 1250
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [1:0]      strap_class,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [7:0]      wr_data,
    output logic [UV_W-1:0] target_uv,
    output logic            ss_done,
    output logic            busy
);
    logic [CODE_W-1:0] code;
    logic [SEL_W-1:0]  rng;
    logic [SEL_W-1:0]  sst;
    logic [UV_W-1:0]   goal_uv;

    ss_cfg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_class (strap_class),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .code_o      (code),
        .range_o     (rng),
        .sstime_o    (sst)
    );

    ss_uv_map #(.UV_W(UV_W)) u_map (
        .code_i  (code),
        .range_i (rng),
        .uv_o    (goal_uv)
    );

    ss_ramp_core #(.UV_W(UV_W), .TRACK_STEP_UV(TRACK_STEP_UV)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .goal_uv   (goal_uv),
        .sstime    (sst),
        .target_uv (target_uv),
        .ss_done   (ss_done),
        .busy      (busy)
    );
endmodule

// File: rtl/ss_setpoint_chk.sv
module ss_setpoint_chk #(
    parameter int unsigned UV_W          = 22,
    parameter int unsigned TRACK_STEP_UV = 1250
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic [UV_W-1:0] target_uv,
    input logic            ss_done,
    input logic            busy
);
    logic [UV_W-1:0] prev_q;
    logic [UV_W-1:0] delta;

    always_ff @(posedge clk) begin
        prev_q <= target_uv;
    end

    assign delta = (target_uv >= prev_q) ? (target_uv - prev_q) : (prev_q - target_uv);

    // R7
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (target_uv == '0) && !ss_done && !busy);

    // R9
    soft_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ss_done && $past(en)) |-> (target_uv >= $past(target_uv)));

    // R4
    done_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_done) |-> (target_uv != '0));

    // R6
    busy_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ss_done);

    // R6
    track_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && $past(ss_done)) |-> (delta <= UV_W'(TRACK_STEP_UV)));
endmodule

bind ss_setpoint_seq ss_setpoint_chk #(.UV_W(UV_W), .TRACK_STEP_UV(TRACK_STEP_UV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .target_uv (target_uv),
    .ss_done   (ss_done),
    .busy      (busy)
);

// File: tb/tb_ss_setpoint_seq.sv
`timescale 1ns/1ps
module tb_ss_setpoint_seq;
    localparam int UV_W = 22;
    localparam int TSTEP = 1250;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [1:0] strap_class = 2'b00;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = 2'b00;
    logic [7:0] wr_data = 8'h00;
    logic [UV_W-1:0] target_uv;
    logic ss_done, busy;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit saw_busy = 0;

    ss_setpoint_seq #(.UV_W(UV_W), .TRACK_STEP_UV(TSTEP)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .strap_class(strap_class),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .target_uv(target_uv), .ss_done(ss_done), .busy(busy)
    );

    always #2.5 clk = ~clk;

    // behavioural reference
    int m_code, m_rng, m_sst, m_ph, m_tgt, m_snap, m_step;

    function automatic int strap_code(input int s);
        case (s)
            0: return 'h46;
            1: return 'h5F;
            2: return 'h5A;
            default: return 'h78;
        endcase
    endfunction

    function automatic int volt(input int c, input int r);
        if (r == 3) return 800000 + c * 10000;
        return 400000 + c * 1250 * (1 << r);
    endfunction

    always @(posedge clk) begin
        int n_code, n_rng, n_sst, n_ph, n_tgt, n_snap, n_step, g;
        started = 1;
        n_code = m_code; n_rng = m_rng; n_sst = m_sst;
        n_ph = m_ph; n_tgt = m_tgt; n_snap = m_snap; n_step = m_step;
        g = volt(m_code, m_rng);
        if (!rst_n) begin
            n_code = strap_code(int'(strap_class)); n_rng = 2; n_sst = 0;
        end else if (wr_en) begin
            if (wr_addr == 0) n_code = int'(wr_data);
            else if (wr_addr == 1) n_rng = int'(wr_data[1:0]);
            else if (wr_addr == 2) n_sst = int'(wr_data[1:0]);
        end
        if (!rst_n || !en) begin
            n_ph = 0; n_tgt = 0; n_snap = 0; n_step = 0;
        end else if (m_ph == 0) begin
            n_ph = 1; n_snap = g; n_step = (g >> (8 + m_sst)) + 1; n_tgt = 0;
        end else if (m_ph == 1) begin
            if (m_tgt + m_step >= m_snap) begin n_tgt = m_snap; n_ph = 2; end
            else n_tgt = m_tgt + m_step;
        end else begin
            if (m_tgt < g) n_tgt = (m_tgt + TSTEP >= g) ? g : m_tgt + TSTEP;
            else if (m_tgt > g) n_tgt = (m_tgt - g <= TSTEP) ? g : m_tgt - TSTEP;
        end
        m_code = n_code; m_rng = n_rng; m_sst = n_sst;
        m_ph = n_ph; m_tgt = n_tgt; m_snap = n_snap; m_step = n_step;
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // cycle compare against the model
    always @(negedge clk) begin
        if (started) begin
            int e_busy;
            e_busy = (m_ph == 2 && m_tgt != volt(m_code, m_rng)) ? 1 : 0;
            check("R4 R6 R9", "target_uv", longint'(target_uv), longint'(m_tgt));
            check("R4 R7", "ss_done", longint'(ss_done), (m_ph == 2) ? 1 : 0);
            check("R6", "busy", longint'(busy), longint'(e_busy));
            if (busy) saw_busy = 1;
        end
    end

    task automatic do_reset(input int s);
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; strap_class = 2'(s);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!ss_done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic wait_idle();
        int c = 0;
        while (busy && c < 5000) begin
            @(negedge clk);
            c++;
        end
    endtask

    initial begin
        int cyc, n, snap, step;
        for (int s = 0; s < 4; s++) begin
            do_reset(s);
            check("R1", "reset target", longint'(target_uv), 0);
            check("R1", "reset done", longint'(ss_done), 0);
            check("R1", "reset busy", longint'(busy), 0);
            en = 1'b1;
            wait_done(cyc);
            check("R1", "strap default voltage", longint'(target_uv),
                  longint'(volt(strap_code(s), 2)));
            en = 1'b0;
            @(negedge clk);
            check("R7", "target after disable", longint'(target_uv), 0);
            check("R7", "done after disable", longint'(ss_done), 0);
        end

        // R3 R8: writes while disabled, address 3 has no effect
        wr(0, 'h20); wr(1, 0); wr(2, 1); wr(3, 'hFF);
        snap = 400000 + 32 * 1250;
        step = (snap >> 9) + 1;
        n = (snap + step - 1) / step;
        en = 1'b1;
        wait_done(cyc);
        check("R3", "setpoint after ignored address", longint'(target_uv), longint'(snap));
        check("R8", "soft start length with time code 01", longint'(cyc), longint'(n + 1));

        // R5 R6: write during soft start
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        repeat (10) @(negedge clk);
        wr(0, 'h80);
        wait_done(cyc);
        check("R5", "ramp ends at snapshot", longint'(target_uv), longint'(snap));
        saw_busy = 0;
        @(negedge clk);
        wait_idle();
        check("R6", "tracked to new setpoint", longint'(target_uv), longint'(400000 + 128 * 1250));
        check("R6", "busy seen while tracking", longint'(saw_busy), 1);

        // R7 mid-ramp disable
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        repeat (20) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R7", "mid-ramp disable target", longint'(target_uv), 0);
        check("R7", "mid-ramp disable done", longint'(ss_done), 0);

        // R2 top of range 11, slowest ramp
        wr(1, 3); wr(0, 255); wr(2, 3);
        en = 1'b1;
        wait_done(cyc);
        check("R2", "range 11 full code", longint'(target_uv), 3350000);
        wr(1, 2);
        @(negedge clk);
        wait_idle();
        check("R6", "downward track to range 10", longint'(target_uv), longint'(400000 + 255 * 5000));
        check("R2", "busy clear at goal", longint'(busy), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule